// File: doc/BRIEF.md
# Variable Phase Step Controller

This block keeps the signed fine-phase position of a clock-management tile and moves it one unit at a time through a strobe-and-done handshake. One unit of position stands for 1/256 of the input clock period (1.40625 degrees), so the position is the sum of a fixed starting offset chosen at build time and every adjustment made since reset. All state is clocked by the dedicated phase-adjust clock.

A client waits for the tile to report lock, then raises the step strobe for exactly one clock together with a direction bit and a latency value. The block sits busy for that many clocks, which stands in for the varying settling time of the real delay line, then applies the step and pulses done for one clock. The position saturates at configurable bounds; an attempt to step past a bound still completes with done, and a limit flag reports that the position sits on a bound. A strobe that lands while a step is still in flight is dropped and recorded in a sticky error flag.

Top module: `phase_step_ctrl`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, pos_o equals INIT_POS and done_o, at_limit_o and proto_err_o are all 0.
- R2: A step strobe sampled while lock_i is 0 and no step is in flight is ignored: no done pulse follows and pos_o is unchanged.
- R3: An accepted step with step_up_i = 1 raises pos_o by one unit and with step_up_i = 0 lowers it by one unit, unless R6 applies.
- R4: done_o is high for exactly one clock per accepted step, and pos_o changes only on the edge that raises done_o.
- R5: done_o rises N clock edges after the edge that accepts the strobe, where N is lat_i sampled on that edge and clamped to the range LAT_MIN to LAT_MAX.
- R6: A step that would take pos_o above POS_MAX or below POS_MIN leaves pos_o unchanged and still produces its done pulse.
- R7: at_limit_o goes to 1 on the done edge of a step that ends with pos_o at POS_MAX or POS_MIN, and stays 1 until a later step ends away from both bounds.
- R8: A strobe sampled while a step is in flight is ignored (it yields no done pulse and no extra move) and sets proto_err_o, which then stays 1 until reset.
- R9: pos_o always lies between POS_MIN and POS_MAX inclusive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase-adjust clock; every register uses its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lock_i | input | 1 | Tile lock indication; steps are accepted only while high |
| step_en_i | input | 1 | One-clock step request strobe |
| step_up_i | input | 1 | Direction: 1 moves up one unit, 0 moves down one unit |
| lat_i | input | LAT_W | Completion latency in clocks for the step being requested |
| pos_o | output | POS_W | Signed total phase position in 1/256-period units |
| done_o | output | 1 | One-clock pulse when a step completes |
| at_limit_o | output | 1 | Position sits on a bound after the latest step |
| proto_err_o | output | 1 | Sticky flag: a strobe arrived while a step was in flight |

## Verification
The bench builds the block with INIT_POS = 4, POS_MAX = 6 and POS_MIN = -5, so both bounds lie within a dozen steps of the start and the saturation, flag-hold and flag-release cases all occur in a short run. The latency window stays at 3 to 10 with a 4-bit lat_i, which lets the bench request values below, inside and above the window and check the clamping of each through the timing of done. A scoreboard predicts the position, the limit flag and the exact done cycle of every accepted step, and any done pulse that was not predicted counts as a mismatch, which covers the lock gating and the in-flight strobe cases.

// File: rtl/phs_pkg.sv
package phs_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } phs_state_e;

    typedef struct packed {
        phs_state_e state;
        logic       dir_up;
        logic       done;
        logic       err;
    } phs_ctl_s;

endpackage

// File: rtl/phs_lat_timer.sv
module phs_lat_timer #(
    parameter int LAT_MIN = 3,
    parameter int LAT_MAX = 10,
    parameter int LAT_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [LAT_W-1:0] lat_i,
    output logic             expire_o
);
    localparam logic [LAT_W-1:0] LO_V  = LAT_W'(LAT_MIN);
    localparam logic [LAT_W-1:0] HI_V  = LAT_W'(LAT_MAX);
    localparam logic [LAT_W-1:0] ONE_V = LAT_W'(1);

    logic [LAT_W-1:0] cnt_d, cnt_q;
    logic [LAT_W-1:0] lat_clamped;

    always_comb begin
        if (lat_i < LO_V)      lat_clamped = LO_V;
        else if (lat_i > HI_V) lat_clamped = HI_V;
        else                   lat_clamped = lat_i;

        cnt_d = cnt_q;
        if (load_i)                 cnt_d = lat_clamped;
        else if (cnt_q != '0)       cnt_d = cnt_q - ONE_V;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire_o = (cnt_q == ONE_V);

endmodule

// File: rtl/phs_pos_acc.sv
module phs_pos_acc #(
    parameter int INIT_POS = 0,
    parameter int POS_MAX  = 255,
    parameter int POS_MIN  = -255,
    parameter int POS_W    = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit_i,
    input  logic                    up_i,
    output logic signed [POS_W-1:0] pos_o,
    output logic                    lim_o
);
    localparam logic signed [POS_W-1:0] HI_P   = POS_W'(POS_MAX);
    localparam logic signed [POS_W-1:0] LO_P   = POS_W'(POS_MIN);
    localparam logic signed [POS_W-1:0] INIT_P = POS_W'(INIT_POS);
    localparam logic signed [POS_W-1:0] UNIT_P = POS_W'(1);

    logic signed [POS_W-1:0] pos_d, pos_q;
    logic                    lim_d, lim_q;
    logic signed [POS_W-1:0] pos_next;

    always_comb begin
        pos_next = pos_q;
        if (up_i) begin
            if (pos_q < HI_P) pos_next = pos_q + UNIT_P;
        end else begin
            if (pos_q > LO_P) pos_next = pos_q - UNIT_P;
        end

        pos_d = pos_q;
        lim_d = lim_q;
        if (commit_i) begin
            pos_d = pos_next;
            lim_d = (pos_next == HI_P) || (pos_next == LO_P);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= INIT_P;
            lim_q <= 1'b0;
        end else begin
            pos_q <= pos_d;
            lim_q <= lim_d;
        end
    end

    assign pos_o = pos_q;
    assign lim_o = lim_q;

endmodule

// File: rtl/phase_step_ctrl.sv
module phase_step_ctrl
    import phs_pkg::*;
#(
    parameter int INIT_POS = 0,
    parameter int POS_MAX  = 255,
    parameter int POS_MIN  = -255,
    parameter int POS_W    = 10,
    parameter int LAT_MIN  = 3,
    parameter int LAT_MAX  = 10,
    parameter int LAT_W    = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lock_i,
    input  logic                    step_en_i,
    input  logic                    step_up_i,
    input  logic [LAT_W-1:0]        lat_i,
    output logic signed [POS_W-1:0] pos_o,
    output logic                    done_o,
    output logic                    at_limit_o,
    output logic                    proto_err_o
);
    phs_ctl_s c_d, c_q;
    logic     accept;
    logic     commit;
    logic     expire;
    logic     busy;

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        accept   = 1'b0;
        commit   = 1'b0;
        case (c_q.state)
            ST_IDLE: begin
                if (step_en_i && lock_i) begin
                    accept     = 1'b1;
                    c_d.dir_up = step_up_i;
                    c_d.state  = ST_BUSY;
                end
            end
            ST_BUSY: begin
                if (step_en_i) c_d.err = 1'b1;
                if (expire) begin
                    commit    = 1'b1;
                    c_d.done  = 1'b1;
                    c_d.state = ST_IDLE;
                end
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{state: ST_IDLE, dir_up: 1'b0, done: 1'b0, err: 1'b0};
        else        c_q <= c_d;
    end

    phs_lat_timer #(
        .LAT_MIN (LAT_MIN),
        .LAT_MAX (LAT_MAX),
        .LAT_W   (LAT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (accept),
        .lat_i    (lat_i),
        .expire_o (expire)
    );

    phs_pos_acc #(
        .INIT_POS (INIT_POS),
        .POS_MAX  (POS_MAX),
        .POS_MIN  (POS_MIN),
        .POS_W    (POS_W)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .up_i     (c_q.dir_up),
        .pos_o    (pos_o),
        .lim_o    (at_limit_o)
    );

    assign busy        = (c_q.state == ST_BUSY);
    assign done_o      = c_q.done;
    assign proto_err_o = c_q.err;

endmodule

// File: rtl/phs_chk.sv
module phs_chk #(
    parameter int POS_MAX = 255,
    parameter int POS_MIN = -255,
    parameter int POS_W   = 10
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    lock_i,
    input logic                    step_en_i,
    input logic                    busy_i,
    input logic signed [POS_W-1:0] pos_o,
    input logic                    done_o,
    input logic                    at_limit_o,
    input logic                    proto_err_o
);
    localparam logic signed [POS_W-1:0] HI_P   = POS_W'(POS_MAX);
    localparam logic signed [POS_W-1:0] LO_P   = POS_W'(POS_MIN);
    localparam logic signed [POS_W-1:0] UNIT_P = POS_W'(1);

    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_pos_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(pos_o));

    p_step_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (pos_o == $past(pos_o)) || (pos_o == $past(pos_o) + UNIT_P)
                   || (pos_o + UNIT_P == $past(pos_o)));

    p_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_o <= HI_P) && (pos_o >= LO_P));

    p_limit_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        at_limit_o |-> (pos_o == HI_P) || (pos_o == LO_P));

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err_o |=> proto_err_o);

    p_lock_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en_i && !lock_i && !busy_i) |=> !busy_i);

    p_busy_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en_i && busy_i) |=> proto_err_o);

endmodule

bind phase_step_ctrl phs_chk #(
    .POS_MAX (POS_MAX),
    .POS_MIN (POS_MIN),
    .POS_W   (POS_W)
) u_phs_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lock_i      (lock_i),
    .step_en_i   (step_en_i),
    .busy_i      (busy),
    .pos_o       (pos_o),
    .done_o      (done_o),
    .at_limit_o  (at_limit_o),
    .proto_err_o (proto_err_o)
);

// File: tb/tb_phase_step_ctrl.sv
module tb_phase_step_ctrl;
    localparam int INIT_POS = 4;
    localparam int POS_MAX  = 6;
    localparam int POS_MIN  = -5;
    localparam int POS_W    = 10;
    localparam int LAT_MIN  = 3;
    localparam int LAT_MAX  = 10;
    localparam int LAT_W    = 4;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    lock_i = 1'b0;
    logic                    step_en_i = 1'b0;
    logic                    step_up_i = 1'b0;
    logic [LAT_W-1:0]        lat_i = '0;
    logic signed [POS_W-1:0] pos_o;
    logic                    done_o;
    logic                    at_limit_o;
    logic                    proto_err_o;

    phase_step_ctrl #(
        .INIT_POS (INIT_POS), .POS_MAX (POS_MAX), .POS_MIN (POS_MIN), .POS_W (POS_W),
        .LAT_MIN  (LAT_MIN),  .LAT_MAX (LAT_MAX), .LAT_W   (LAT_W)
    ) dut (
        .clk (clk), .rst_n (rst_n), .lock_i (lock_i), .step_en_i (step_en_i),
        .step_up_i (step_up_i), .lat_i (lat_i), .pos_o (pos_o), .done_o (done_o),
        .at_limit_o (at_limit_o), .proto_err_o (proto_err_o)
    );

    always #4 clk = ~clk;

    typedef struct {
        int pos;
        bit lim;
        int due;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    int   cyc = 0;
    int   done_seen = 0;
    bit   prev_done = 1'b0;
    int   mpos = INIT_POS;
    bit   mlim = 1'b0;
    bit   finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic void chk(bit ok, string req, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endfunction

    // Monitor: compares every done pulse against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o) begin
                done_seen++;
                chk(!prev_done, "R4 done width", 1, 0);
                if (q.size() == 0) begin
                    chk(1'b0, "R2/R8 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(int'(pos_o) == e.pos, "R3/R6 position", int'(pos_o), e.pos);
                    chk(at_limit_o == e.lim, "R7 limit flag", int'(at_limit_o), int'(e.lim));
                    chk(cyc == e.due, "R5 done cycle", cyc, e.due);
                end
            end else if (q.size() != 0 && cyc > q[0].due) begin
                chk(1'b0, "R5 missing done", cyc, q[0].due);
                void'(q.pop_front());
            end
            prev_done = done_o;
        end else begin
            prev_done = 1'b0;
        end
    end

    function automatic int clamp_lat(int l);
        if (l < LAT_MIN) return LAT_MIN;
        if (l > LAT_MAX) return LAT_MAX;
        return l;
    endfunction

    task automatic step(input bit up, input int lat);
        @(negedge clk);
        step_up_i = up;
        lat_i     = LAT_W'(lat);
        step_en_i = 1'b1;
        if (up && mpos < POS_MAX) mpos++;
        if (!up && mpos > POS_MIN) mpos--;
        mlim = (mpos == POS_MAX) || (mpos == POS_MIN);
        q.push_back('{mpos, mlim, cyc + 1 + clamp_lat(lat)});
        @(negedge clk);
        step_en_i = 1'b0;
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        q.delete();
        mpos = INIT_POS;
        mlim = 1'b0;
        @(negedge clk);
        chk(int'(pos_o) == INIT_POS, "R1 reset position", int'(pos_o), INIT_POS);
        chk({done_o, at_limit_o, proto_err_o} == 3'b000, "R1 reset flags",
            int'({done_o, at_limit_o, proto_err_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(int'(pos_o) == INIT_POS, "R1 position after release", int'(pos_o), INIT_POS);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        chk(1'b0, "watchdog", cyc, 0);
        report();
    end

    initial begin
        int ds;
        repeat (3) @(negedge clk);
        do_reset();

        // R2: strobe without lock
        ds = done_seen;
        @(negedge clk);
        step_up_i = 1'b1; lat_i = 4'd3; step_en_i = 1'b1;
        @(negedge clk);
        step_en_i = 1'b0;
        repeat (14) @(negedge clk);
        chk(done_seen == ds, "R2 no done without lock", done_seen - ds, 0);
        chk(int'(pos_o) == INIT_POS, "R2 position held", int'(pos_o), INIT_POS);

        lock_i = 1'b1;
        @(negedge clk);

        // R3, R5, R6, R7 going up
        step(1'b1, 3);    // 5
        step(1'b1, 0);    // 6, clamped to 3, at limit
        step(1'b1, 15);   // pinned at 6, clamped to 10
        chk(int'(pos_o) == POS_MAX, "R6 pinned at upper bound", int'(pos_o), POS_MAX);
        step(1'b0, 7);    // 5, flag released
        chk(at_limit_o == 1'b0, "R7 flag released", int'(at_limit_o), 0);

        // walk down to lower bound and past it
        for (int i = 0; i < 10; i++) step(1'b0, 4);
        chk(int'(pos_o) == POS_MIN, "R9 lower bound reached", int'(pos_o), POS_MIN);
        step(1'b0, 5);
        chk(int'(pos_o) == POS_MIN && at_limit_o, "R6 pinned at lower bound", int'(pos_o), POS_MIN);
        step(1'b1, 8);    // -4

        // R8: second strobe while busy
        ds = done_seen;
        @(negedge clk);
        step_up_i = 1'b1; lat_i = 4'd6; step_en_i = 1'b1;
        mpos++;
        mlim = 1'b0;
        q.push_back('{mpos, mlim, cyc + 1 + 6});
        @(negedge clk);
        step_en_i = 1'b0;
        @(negedge clk);
        step_up_i = 1'b0; step_en_i = 1'b1;
        @(negedge clk);
        step_en_i = 1'b0;
        repeat (16) @(negedge clk);
        chk(done_seen - ds == 1, "R8 single done for busy strobe", done_seen - ds, 1);
        chk(int'(pos_o) == -3, "R8 position after busy strobe", int'(pos_o), -3);
        chk(proto_err_o == 1'b1, "R8 error flag set", int'(proto_err_o), 1);
        step(1'b1, 3);
        chk(proto_err_o == 1'b1, "R8 error flag sticky", int'(proto_err_o), 1);

        // R1: reset in the middle of a step
        @(negedge clk);
        step_up_i = 1'b1; lat_i = 4'd9; step_en_i = 1'b1;
        @(negedge clk);
        step_en_i = 1'b0;
        repeat (3) @(negedge clk);
        do_reset();
        repeat (12) @(negedge clk);
        chk(int'(pos_o) == INIT_POS, "R1 no late commit after reset", int'(pos_o), INIT_POS);
        step(1'b0, 3);
        chk(int'(pos_o) == INIT_POS - 1, "R3 decrement after reset", int'(pos_o), INIT_POS - 1);

        report();
    end

endmodule